// File: doc/BRIEF.md
# Phase to delay-line encoder

This block turns a requested clock phase, in whole degrees from 0 to 359, into the control word of a two-stage phase circuit: a coarse selector that picks one of four 90-degree steps, and a fine tapped delay line whose taps are taken as 60 ps each. The angle is split into a step index and a remainder. The remainder is turned into a tap count using the live card-clock rate, which is half the supplied source-clock rate. The count is rounded to nearest, clipped to the 8-bit range, and packed into a 32-bit write-masked register image whose upper half enables only the bits the field occupies.

The same block also runs the reverse operation. It takes a stored 16-bit register image and a clock rate and returns the approximate phase that image produces, reduced modulo 360. Both directions share one restoring divider. A request is issued with `start`, and `done` is raised when the result is ready. The result stays on the outputs until the next accepted request.

The controller has six states. IDLE accepts a request. Results that need no division (errors, an exact multiple of 90, a decode with zero rate or with the fine delay off) complete directly from IDLE. ENC_RATE divides the card rate by 1000, and ENC_TAPS performs the rounded tap division; both lead back to IDLE. DEC_RATE divides the card rate by 10000, DEC_PROD performs the rounded division of the delay product by one million, and DEC_WRAP reduces the sum modulo 360 and returns to IDLE. Each division state moves on when the divider signals completion.

Top module: `phase_tap_encoder`

## Requirements
- R1: After reset, `done`, `err`, `target_sample`, `reg_word` and `phase_deg` are all zero.
- R2: An encode places degrees/90 in `reg_word[2:1]`.
- R3: With card rate C = floor(src_rate/2), remainder r = degrees mod 90 and D = floor(C/1000)*216, an encode places round-half-up(r*10000000/D) in `reg_word[10:3]`. A remainder of 0 gives 0 taps.
- R4: The tap count saturates at 255. When r is nonzero and D is 0 (card rate below 1000 Hz), the count is 255.
- R5: `reg_word[11]` (fine-delay enable) is 1 exactly when the tap count is nonzero.
- R6: A successful encode sets the mask bits `reg_word[27:17]` to all ones and clears bits 31:28, 16:12 and 0.
- R7: An encode with card rate 0 or with degrees above 359 ends with `err`=1 and `reg_word`=0.
- R8: A decode reads step q from `stored_img[2:1]`, taps t from `stored_img[10:3]` and enable e from `stored_img[11]`. It returns `phase_deg` = (q*90 + (e ? round-half-up(t*216*floor(C/10000)/1000000) : 0)) mod 360, or 0 when C is 0, with `err`=0. It leaves `reg_word` unchanged.
- R9: `done` and all results hold until the next accepted `start`. A `start` while a request is in progress is ignored. `target_sample` reflects `sel_sample` as captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| decode_mode | input | 1 | 0 = encode degrees, 1 = decode stored image |
| sel_sample | input | 1 | Target select: 1 sample phase, 0 drive phase |
| degrees | input | 9 | Requested phase in degrees |
| src_rate | input | 32 | Source clock rate in Hz (card rate is half of it) |
| stored_img | input | 16 | Stored register image to decode |
| done | output | 1 | Result valid, held until next accepted start |
| err | output | 1 | Encode request rejected |
| target_sample | output | 1 | Captured target select |
| reg_word | output | 32 | Write-masked register image from the last encode |
| phase_deg | output | 9 | Phase from the last decode |

## Verification
A wrong step index or remainder shows up directly in `reg_word[2:1]` or in the tap field of the very next encode result. A divider that loses or adds a bit, or a rounding offset applied at the wrong stage, shows up as a tap count or decoded phase that is off by one or more in the same transaction. The sweep walks every angle at two rates, which exposes such a slip at every remainder. A stray state transition would either drop `done` while idle or let a second `start` replace the operands. The ignored-start check and the hold check detect that within a few cycles of completion.

// File: rtl/ptap_pkg.sv
package ptap_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ENC_RATE,
        S_ENC_TAPS,
        S_DEC_RATE,
        S_DEC_PROD,
        S_DEC_WRAP
    } ptap_state_e;

    localparam int unsigned DEG_W    = 9;
    localparam int unsigned RATE_W   = 32;
    localparam int unsigned TAP_W    = 8;
    localparam int unsigned STEP_DEG = 90;
    localparam int unsigned FULL_DEG = 360;
    localparam int unsigned TAP_FACT = 216;     // 36 * (60 ps / 10)
    localparam int unsigned ENC_NUM  = 10000000;
    localparam int unsigned ENC_RDIV = 1000;
    localparam int unsigned DEC_RDIV = 10000;
    localparam int unsigned DEC_DDIV = 1000000;
endpackage

// File: rtl/ptap_split.sv
module ptap_split
    import ptap_pkg::*;
(
    input  logic [DEG_W-1:0] deg,
    output logic [1:0]       quad,
    output logic [6:0]       rem,
    output logic             bad
);
    logic [DEG_W-1:0] base;

    always_comb begin
        bad = (deg >= DEG_W'(FULL_DEG));
        if (deg < DEG_W'(STEP_DEG)) begin
            quad = 2'd0; base = DEG_W'(0);
        end else if (deg < DEG_W'(2*STEP_DEG)) begin
            quad = 2'd1; base = DEG_W'(STEP_DEG);
        end else if (deg < DEG_W'(3*STEP_DEG)) begin
            quad = 2'd2; base = DEG_W'(2*STEP_DEG);
        end else begin
            quad = 2'd3; base = DEG_W'(3*STEP_DEG);
        end
        rem = 7'(deg - base);
    end
endmodule

// File: rtl/ptap_divider.sv
module ptap_divider #(
    parameter int unsigned W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rmd
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W:0]    acc;
    logic [W:0]    trial;
    logic [W-1:0]  q;
    logic [W-1:0]  d;
    logic [CW-1:0] cnt;

    always_comb trial = {acc[W-1:0], q[W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            q    <= '0;
            d    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                acc  <= '0;
                q    <= num;
                d    <= den;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, d}) begin
                    acc <= trial - {1'b0, d};
                    q   <= {q[W-2:0], 1'b1};
                end else begin
                    acc <= trial;
                    q   <= {q[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q;
    assign rmd  = acc[W-1:0];

    // R3
    rem_lt_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && d != '0) |-> (acc < {1'b0, d}));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/phase_tap_encoder.sv
module phase_tap_encoder
    import ptap_pkg::*;
#(
    parameter int unsigned DW = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              decode_mode,
    input  logic              sel_sample,
    input  logic [DEG_W-1:0]  degrees,
    input  logic [RATE_W-1:0] src_rate,
    input  logic [15:0]       stored_img,
    output logic              done,
    output logic              err,
    output logic              target_sample,
    output logic [31:0]       reg_word,
    output logic [DEG_W-1:0]  phase_deg
);
    localparam logic [DW-1:0] K_ENC_NUM  = DW'(ENC_NUM);
    localparam logic [DW-1:0] K_ENC_RDIV = DW'(ENC_RDIV);
    localparam logic [DW-1:0] K_DEC_RDIV = DW'(DEC_RDIV);
    localparam logic [DW-1:0] K_DEC_DDIV = DW'(DEC_DDIV);
    localparam logic [DW-1:0] K_FULL     = DW'(FULL_DEG);
    localparam logic [DW-1:0] K_FACT     = DW'(TAP_FACT);
    localparam logic [DW-1:0] K_STEP     = DW'(STEP_DEG);
    localparam logic [DW-1:0] K_TAPMAX   = DW'((1 << TAP_W) - 1);

    ptap_state_e state, nxt;

    logic [RATE_W-1:0] card;
    logic [1:0]        sp_quad;
    logic [6:0]        sp_rem;
    logic              sp_bad;
    logic              img_en;

    logic [1:0]        quad_q;
    logic [6:0]        rem_q;
    logic [TAP_W-1:0]  tap_q;

    logic              div_go;
    logic [DW-1:0]     div_num, div_den, div_quot, div_rmd;
    logic              div_busy, div_done;
    logic [DW-1:0]     dly_den;

    assign card   = src_rate >> 1;
    assign img_en = stored_img[11];
    assign dly_den = div_quot * K_FACT;

    ptap_split u_split (
        .deg  (degrees),
        .quad (sp_quad),
        .rem  (sp_rem),
        .bad  (sp_bad)
    );

    ptap_divider #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot),
        .rmd   (div_rmd)
    );

    function automatic logic [31:0] pack_word(input logic [1:0] qd,
                                              input logic [TAP_W-1:0] tp);
        logic [31:0] w;
        w        = '0;
        w[27:17] = '1;
        w[11]    = |tp;
        w[10:3]  = tp;
        w[2:1]   = qd;
        return w;
    endfunction

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (decode_mode) begin
                        if (card != '0 && img_en) nxt = S_DEC_RATE;
                    end else if (card != '0 && !sp_bad && sp_rem != '0) begin
                        nxt = S_ENC_RATE;
                    end
                end
            end
            S_ENC_RATE: if (div_done) nxt = S_ENC_TAPS;
            S_ENC_TAPS: if (div_done) nxt = S_IDLE;
            S_DEC_RATE: if (div_done) nxt = S_DEC_PROD;
            S_DEC_PROD: if (div_done) nxt = S_DEC_WRAP;
            S_DEC_WRAP: if (div_done) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done          <= 1'b0;
            err           <= 1'b0;
            target_sample <= 1'b0;
            reg_word      <= '0;
            phase_deg     <= '0;
            quad_q        <= '0;
            rem_q         <= '0;
            tap_q         <= '0;
            div_go        <= 1'b0;
            div_num       <= '0;
            div_den       <= '0;
        end else begin
            div_go <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        done          <= 1'b0;
                        target_sample <= sel_sample;
                        rem_q         <= sp_rem;
                        tap_q         <= stored_img[10:3];
                        quad_q        <= decode_mode ? stored_img[2:1] : sp_quad;
                        if (decode_mode) begin
                            err <= 1'b0;
                            if (card == '0) begin
                                phase_deg <= '0;
                                done      <= 1'b1;
                            end else if (!img_en) begin
                                phase_deg <= DEG_W'(stored_img[2:1]) * DEG_W'(STEP_DEG);
                                done      <= 1'b1;
                            end else begin
                                div_go  <= 1'b1;
                                div_num <= DW'(card);
                                div_den <= K_DEC_RDIV;
                            end
                        end else if (card == '0 || sp_bad) begin
                            err      <= 1'b1;
                            reg_word <= '0;
                            done     <= 1'b1;
                        end else if (sp_rem == '0) begin
                            err      <= 1'b0;
                            reg_word <= pack_word(sp_quad, '0);
                            done     <= 1'b1;
                        end else begin
                            div_go  <= 1'b1;
                            div_num <= DW'(card);
                            div_den <= K_ENC_RDIV;
                        end
                    end
                end
                S_ENC_RATE: begin
                    if (div_done) begin
                        div_go  <= 1'b1;
                        div_num <= DW'(rem_q) * K_ENC_NUM + (dly_den >> 1);
                        div_den <= dly_den;
                    end
                end
                S_ENC_TAPS: begin
                    if (div_done) begin
                        reg_word <= pack_word(quad_q,
                            (div_quot > K_TAPMAX) ? TAP_W'(K_TAPMAX) : div_quot[TAP_W-1:0]);
                        err  <= 1'b0;
                        done <= 1'b1;
                    end
                end
                S_DEC_RATE: begin
                    if (div_done) begin
                        div_go  <= 1'b1;
                        div_num <= DW'(tap_q) * K_FACT * div_quot + (K_DEC_DDIV >> 1);
                        div_den <= K_DEC_DDIV;
                    end
                end
                S_DEC_PROD: begin
                    if (div_done) begin
                        div_go  <= 1'b1;
                        div_num <= DW'(quad_q) * K_STEP + div_quot;
                        div_den <= K_FULL;
                    end
                end
                S_DEC_WRAP: begin
                    if (div_done) begin
                        phase_deg <= div_rmd[DEG_W-1:0];
                        done      <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && done && !start) |=> (done && $stable(reg_word) && $stable(phase_deg)));

    // R7
    err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (reg_word == '0));

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_deg < DEG_W'(FULL_DEG));

    // R5
    tap_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_word[11] == (reg_word[10:3] != '0));

    // R6
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word != '0) |-> (reg_word[27:17] == '1 && reg_word[31:28] == '0 &&
                              reg_word[16:12] == '0 && reg_word[0] == 1'b0));

    // R9
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> !done);
endmodule

// File: tb/tb_phase_tap_encoder.sv
module tb_phase_tap_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        decode_mode = 1'b0;
    logic        sel_sample = 1'b0;
    logic [8:0]  degrees = '0;
    logic [31:0] src_rate = '0;
    logic [15:0] stored_img = '0;
    logic        done, err, target_sample;
    logic [31:0] reg_word;
    logic [8:0]  phase_deg;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit hung = 1'b0;

    always #2 clk = ~clk;

    phase_tap_encoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .decode_mode(decode_mode),
        .sel_sample(sel_sample), .degrees(degrees), .src_rate(src_rate),
        .stored_img(stored_img), .done(done), .err(err),
        .target_sample(target_sample), .reg_word(reg_word), .phase_deg(phase_deg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 195000) begin
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 195000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    function automatic longint unsigned exp_word(input int deg, input longint unsigned src,
                                                 output bit e);
        longint unsigned c, r, d, t, w;
        c = src / 2;
        e = 1'b0;
        if (c == 0 || deg > 359) begin
            e = 1'b1;
            return 0;
        end
        r = deg % 90;
        if (r == 0) t = 0;
        else begin
            d = (c / 1000) * 216;
            if (d == 0) t = 255;
            else t = (r * 10000000 + d / 2) / d;
            if (t > 255) t = 255;
        end
        w = 64'h0FFE_0000 | (t << 3) | ((deg / 90) << 1);
        if (t != 0) w = w | (1 << 11);
        return w;
    endfunction

    function automatic int exp_phase(input logic [15:0] img, input longint unsigned src);
        longint unsigned c, s;
        c = src / 2;
        if (c == 0) return 0;
        s = img[2:1] * 90;
        if (img[11]) s = s + (img[10:3] * 216 * (c / 10000) + 500000) / 1000000;
        return int'(s % 360);
    endfunction

    task automatic wait_done();
        int guard = 0;
        while (!done && !hung) begin
            @(negedge clk);
            guard++;
            if (guard > 2000) hung = 1'b1;
        end
    endtask

    task automatic issue(input bit dm, input bit sel, input int deg,
                         input longint unsigned src, input logic [15:0] img);
        @(negedge clk);
        decode_mode = dm;
        sel_sample  = sel;
        degrees     = 9'(deg);
        src_rate    = 32'(src);
        stored_img  = img;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic chk_enc(input string tag, input int deg, input longint unsigned src);
        bit e;
        longint unsigned w;
        w = exp_word(deg, src, e);
        issue(1'b0, deg[0], deg, src, '0);
        tests++;
        if (hung || reg_word != 32'(w) || err != e || target_sample != deg[0]) begin
            fails++;
            $display("FAIL %s encode deg=%0d src=%0d: actual word=%h err=%0d sel=%0d expected word=%h err=%0d sel=%0d",
                     tag, deg, src, reg_word, err, target_sample, 32'(w), e, deg[0]);
        end
    endtask

    task automatic chk_dec(input string tag, input logic [15:0] img, input longint unsigned src);
        int p;
        logic [31:0] w_before;
        w_before = reg_word;
        p = exp_phase(img, src);
        issue(1'b1, 1'b1, 0, src, img);
        tests++;
        if (hung || phase_deg != 9'(p) || err != 1'b0 || reg_word != w_before) begin
            fails++;
            $display("FAIL %s decode img=%h src=%0d: actual phase=%0d err=%0d word=%h expected phase=%0d err=0 word=%h",
                     tag, img, src, phase_deg, err, reg_word, p, w_before);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        tests++;
        if (done || err || target_sample || reg_word != 0 || phase_deg != 0) begin
            fails++;
            $display("FAIL R1 reset: actual done=%0d err=%0d sel=%0d word=%h phase=%0d expected all zero",
                     done, err, target_sample, reg_word, phase_deg);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R6: full angle sweeps at two rates, with round-trip decode (R8)
        for (int d = 0; d < 360; d++) begin
            chk_enc("R2/R3", d, 64'd50_000_000);
            if (d % 4 == 1) chk_dec("R8", reg_word[15:0], 64'd50_000_000);
        end
        for (int d = 0; d < 360; d++) begin
            chk_enc("R3/R5", d, 64'd300_000_000);
            if (d % 4 == 3) chk_dec("R8", reg_word[15:0], 64'd300_000_000);
        end
        // R4 saturation: slow card clock and below-1000 Hz card clock
        for (int d = 0; d < 360; d += 7) chk_enc("R4", d, 64'd800_000);
        for (int d = 0; d < 360; d += 13) chk_enc("R4", d, 64'd1999);
        // R5 tap count rounding to zero at the highest rate
        for (int d = 0; d < 360; d += 11) chk_enc("R5", d, 64'd4_294_967_295);
        // R7 error cases
        chk_enc("R7", 45, 64'd0);
        chk_enc("R7", 200, 64'd1);
        for (int d = 360; d < 512; d += 19) chk_enc("R7", d, 64'd100_000_000);
        chk_enc("R7", 511, 64'd100_000_000);
        // R8 decode of arbitrary images, including zero rate
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            chk_dec("R8", lfsr, (i % 2 == 0) ? 64'd100_000_000 : 64'd3_000_000_000);
        end
        chk_dec("R8", 16'h0FFE, 64'd0);
        chk_dec("R8", 16'h0FFE, 64'd4_294_967_295);
        chk_dec("R8", 16'h0006, 64'd50_000_000);

        // R9 start during busy is ignored, results hold
        begin
            bit e;
            longint unsigned w;
            w = exp_word(45, 64'd50_000_000, e);
            @(negedge clk);
            decode_mode = 1'b0; sel_sample = 1'b1; degrees = 9'd45;
            src_rate = 32'd50_000_000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            degrees = 9'd300; sel_sample = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            tests++;
            if (hung || reg_word != 32'(w) || target_sample != 1'b1) begin
                fails++;
                $display("FAIL R9 ignored start: actual word=%h sel=%0d expected word=%h sel=1",
                         reg_word, target_sample, 32'(w));
            end
            degrees = 9'd10;
            repeat (6) @(negedge clk);
            tests++;
            if (!done || reg_word != 32'(w) || target_sample != 1'b1) begin
                fails++;
                $display("FAIL R9 hold: actual done=%0d word=%h expected done=1 word=%h",
                         done, reg_word, 32'(w));
            end
        end

        if (hung) begin
            fails++;
            $display("FAIL watchdog: an operation never completed, actual done=0 expected done=1");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule